// File: doc/BRIEF.md
# Flash Address Range Guard

This block sits between a flash access sequencer and the flash bus. It holds four protection entries. Each entry names one block of the flash window, either 4 KiB or 64 KiB long, and says whether reads, writes or both are guarded there. A separate opcode register lists up to four command bytes that are refused inside a guarded block. That register can be written once per reset. For every access request the block returns an allow or deny verdict one cycle later.

Configuration arrives on a simple write port. The window base is a 16-bit value that becomes the upper half of the 32-bit system address. The four entries can be rewritten at any time. A sticky violation flag records that at least one access was denied. Software clears it by writing 1 to its clear code.

Top module: `flash_range_guard`

## Requirements
- R1: After reset, respValid, respDeny and violation are 0. All entries, the window base and the opcode register are zero, so no request is denied.
- R2: An entry is written with cfgAddr 0 to 3. Its fields are: bits 7:0 hold the block index, bit 8 selects the size (1 = 64 KiB, 0 = 4 KiB), bit 9 guards writes and bit 10 guards reads. Bits 31:11 are dropped. An entry whose stored 11 bits are all zero is inactive.
- R3: An active entry covers the addresses from base + index × size through base + (index + 1) × size − 1, where base = {window, 16'h0000}. Addresses below base never match.
- R4: cfgAddr 4 loads the window value from cfgWrData[15:0].
- R5: cfgAddr 5 loads the opcode register from cfgWrData[31:0]. It holds four byte lanes, and a request opcode matches when it equals any nonzero lane. A zero lane never matches, so opcode 8'h00 is never refused.
- R6: Only the first write to cfgAddr 5 after reset takes effect. Later writes are ignored until the next reset.
- R7: A request is denied only when three things hold: its address falls in an active entry, that entry guards the request's direction (reqWrite = 1 is a write), and its opcode matches the opcode register.
- R8: respValid is high in the cycle after a cycle in which reqValid is sampled high, and low otherwise. respDeny carries the verdict in that cycle and is 0 whenever respValid is 0.
- R9: violation rises together with any respDeny. It stays set until a write to cfgAddr 6 with cfgWrData[0] = 1. A deny in the same cycle as that clear leaves violation set.
- R10: With several entries active, a request is denied when any one of them satisfies R7.
- R11: A configuration write takes effect for requests sampled in later cycles. A request sampled in the same cycle as the write is judged with the previous setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration target code |
| cfgWrData | input | 32 | Configuration write data |
| reqValid | input | 1 | Access request present |
| reqOpcode | input | 8 | Flash command byte of the request |
| reqAddr | input | 32 | System address of the request |
| reqWrite | input | 1 | 1 = write direction, 0 = read direction |
| respValid | output | 1 | Verdict available |
| respDeny | output | 1 | Request refused |
| violation | output | 1 | Sticky record of a refused request |

## Verification
Two pairs of events can fall in the same clock cycle. In the first pair, a refused request arrives while software clears the violation flag. In the second pair, a request arrives while the configuration it depends on is being rewritten. The bench raises the request and the configuration write on the same falling edge to provoke each collision. One cycle later it expects the flag still set in the first case, and the verdict taken from the old entry in the second. The table walk covers the edges of each block, each size and each direction flag, including the zero opcode lane.

// File: rtl/frg_pkg.sv
package frg_pkg;
  localparam int FRG_RANGES     = 4;
  localparam int FRG_ADDR_W     = 32;
  localparam int FRG_BASE_W     = 16;
  localparam int FRG_IDX_W      = 8;
  localparam int FRG_OPC_W      = 8;
  localparam int FRG_CMD_LANES  = 4;
  localparam int FRG_CFG_W      = FRG_OPC_W * FRG_CMD_LANES;
  localparam int FRG_BASE_SHIFT = FRG_ADDR_W - FRG_BASE_W;
  localparam int FRG_SMALL_LOG2 = 12;
  localparam int FRG_LARGE_LOG2 = 16;

  // Entry field positions (decoded by the datapath)
  localparam int F_UNIT  = FRG_IDX_W;
  localparam int F_WP    = FRG_IDX_W + 1;
  localparam int F_RP    = FRG_IDX_W + 2;
  localparam int ENTRY_W = FRG_IDX_W + 3;

  // Configuration target codes
  localparam int CFG_ADDR_W = $clog2(FRG_RANGES + 3);
  localparam logic [CFG_ADDR_W-1:0] CFG_BASE = CFG_ADDR_W'(FRG_RANGES);
  localparam logic [CFG_ADDR_W-1:0] CFG_CMD  = CFG_ADDR_W'(FRG_RANGES + 1);
  localparam logic [CFG_ADDR_W-1:0] CFG_CLR  = CFG_ADDR_W'(FRG_RANGES + 2);

  typedef struct packed {
    logic [FRG_RANGES-1:0] entryWr;
    logic                  baseWr;
    logic                  cmdWr;
    logic                  violClr;
  } frgStrobe_t;
endpackage

// File: rtl/frg_ctrl.sv
module frg_ctrl
  import frg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWrEn,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  input  logic                  cfgClrBit,
  output frgStrobe_t            strb
);
  logic cmdLockedQ;

  always_comb begin
    strb = '0;
    for (int i = 0; i < FRG_RANGES; i++) begin
      strb.entryWr[i] = cfgWrEn && (cfgAddr == CFG_ADDR_W'(i));
    end
    strb.baseWr  = cfgWrEn && (cfgAddr == CFG_BASE);
    strb.cmdWr   = cfgWrEn && (cfgAddr == CFG_CMD) && !cmdLockedQ;
    strb.violClr = cfgWrEn && (cfgAddr == CFG_CLR) && cfgClrBit;
  end

  // Once the opcode register has taken a write, it stays locked until reset
  always_ff @(posedge clk) begin
    if (!rstN)           cmdLockedQ <= 1'b0;
    else if (strb.cmdWr) cmdLockedQ <= 1'b1;
  end
endmodule

// File: rtl/frg_datapath.sv
module frg_datapath
  import frg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  frgStrobe_t            strb,
  input  logic [FRG_CFG_W-1:0]  cfgWrData,
  input  logic                  reqValid,
  input  logic [FRG_OPC_W-1:0]  reqOpcode,
  input  logic [FRG_ADDR_W-1:0] reqAddr,
  input  logic                  reqWrite,
  output logic                  respValid,
  output logic                  respDeny,
  output logic                  violation
);
  logic [FRG_BASE_W-1:0]    baseQ;
  logic [FRG_CFG_W-1:0]     cmdQ;
  logic [FRG_ADDR_W-1:0]    windowBase;
  logic [FRG_ADDR_W-1:0]    offset;
  logic                     aboveBase;
  logic [FRG_RANGES-1:0]    entryDeny;
  logic [FRG_CMD_LANES-1:0] laneHit;
  logic                     denyNext;
  logic                     violQ;
  logic                     cmdSeenQ;

  always_ff @(posedge clk) begin
    if (!rstN)            baseQ <= '0;
    else if (strb.baseWr) baseQ <= cfgWrData[FRG_BASE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)           cmdQ <= '0;
    else if (strb.cmdWr) cmdQ <= cfgWrData;
  end

  assign windowBase = {baseQ, {FRG_BASE_SHIFT{1'b0}}};
  assign offset     = reqAddr - windowBase;
  assign aboveBase  = reqAddr >= windowBase;

  for (genvar g = 0; g < FRG_RANGES; g++) begin : gEntry
    logic [ENTRY_W-1:0]    eQ;
    logic [FRG_ADDR_W-1:0] blkNum;
    logic                  hit;
    logic                  dirOk;

    always_ff @(posedge clk) begin
      if (!rstN)                eQ <= '0;
      else if (strb.entryWr[g]) eQ <= cfgWrData[ENTRY_W-1:0];
    end

    assign blkNum = eQ[F_UNIT] ? (offset >> FRG_LARGE_LOG2) : (offset >> FRG_SMALL_LOG2);
    assign hit    = (eQ != '0) && aboveBase && (blkNum == FRG_ADDR_W'(eQ[FRG_IDX_W-1:0]));
    assign dirOk  = reqWrite ? eQ[F_WP] : eQ[F_RP];
    assign entryDeny[g] = hit && dirOk;
  end

  for (genvar l = 0; l < FRG_CMD_LANES; l++) begin : gLane
    logic [FRG_OPC_W-1:0] laneVal;
    assign laneVal    = cmdQ[l*FRG_OPC_W +: FRG_OPC_W];
    assign laneHit[l] = (laneVal != '0) && (laneVal == reqOpcode);
  end

  assign denyNext = reqValid && (|entryDeny) && (|laneHit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respDeny  <= 1'b0;
      violQ     <= 1'b0;
    end else begin
      respValid <= reqValid;
      respDeny  <= denyNext;
      if (denyNext)          violQ <= 1'b1;
      else if (strb.violClr) violQ <= 1'b0;
    end
  end

  assign violation = violQ;

  // Assertion-only record of the first opcode-register write
  always_ff @(posedge clk) begin
    if (!rstN)           cmdSeenQ <= 1'b0;
    else if (strb.cmdWr) cmdSeenQ <= 1'b1;
  end

  AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN) reqValid |=> respValid); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN) !reqValid |=> (!respValid && !respDeny)); // R8
  AST_DENY_MARKS_VIOL: assert property (@(posedge clk) disable iff (!rstN) respDeny |-> violQ); // R9
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rstN) (violQ && !strb.violClr) |=> violQ); // R9
  AST_CMD_ONCE: assert property (@(posedge clk) disable iff (!rstN) cmdSeenQ |-> !strb.cmdWr); // R6
  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rstN) cmdSeenQ |=> $stable(cmdQ)); // R6
endmodule

// File: rtl/flash_range_guard.sv
module flash_range_guard
  import frg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWrEn,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  input  logic [FRG_CFG_W-1:0]  cfgWrData,
  input  logic                  reqValid,
  input  logic [FRG_OPC_W-1:0]  reqOpcode,
  input  logic [FRG_ADDR_W-1:0] reqAddr,
  input  logic                  reqWrite,
  output logic                  respValid,
  output logic                  respDeny,
  output logic                  violation
);
  frgStrobe_t strb;

  frg_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .cfgClrBit (cfgWrData[0]),
    .strb      (strb)
  );

  frg_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cfgWrData (cfgWrData),
    .reqValid  (reqValid),
    .reqOpcode (reqOpcode),
    .reqAddr   (reqAddr),
    .reqWrite  (reqWrite),
    .respValid (respValid),
    .respDeny  (respDeny),
    .violation (violation)
  );
endmodule

// File: tb/flash_range_guard_bench.sv
module flash_range_guard_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic        reqValid = 1'b0;
  logic [7:0]  reqOpcode = '0;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic        respValid, respDeny, violation;
  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  flash_range_guard u_flash_range_guard (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .reqValid(reqValid), .reqOpcode(reqOpcode), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .respValid(respValid), .respDeny(respDeny), .violation(violation)
  );

  // {opcode, address, write, expectedDeny}
  // window FF00; e0 idx2 4K WP; e1 idx1 64K RP; e2 idx10 64K WP|RP; opcodes 02,D8,03
  localparam logic [41:0] VEC [14] = '{
    {8'hD8, 32'hFF002000, 1'b1, 1'b1},  // R3 first byte of e0
    {8'hD8, 32'hFF002FFF, 1'b1, 1'b1},  // R3 last byte of e0
    {8'hD8, 32'hFF003000, 1'b1, 1'b0},  // R3 one past e0
    {8'hD8, 32'hFF001FFF, 1'b1, 1'b0},  // R3 one before e0
    {8'h03, 32'hFF002100, 1'b0, 1'b0},  // R7 read in write-only entry
    {8'h03, 32'hFF010000, 1'b0, 1'b1},  // R10 e1 read guard
    {8'h02, 32'hFF010000, 1'b1, 1'b0},  // R7 write in read-only entry
    {8'h03, 32'hFF01FFFF, 1'b0, 1'b1},  // R3 64K end
    {8'h03, 32'hFF020000, 1'b0, 1'b0},  // R3 64K past end
    {8'h0B, 32'hFF100000, 1'b0, 1'b0},  // R5 unlisted opcode
    {8'h02, 32'hFF10FFFF, 1'b1, 1'b1},  // R10 e2 write guard
    {8'h00, 32'hFF100000, 1'b1, 1'b0},  // R5 zero lane never matches
    {8'hD8, 32'h00002000, 1'b1, 1'b0},  // R3 below window base
    {8'h02, 32'hFF002000, 1'b0, 1'b0}   // R7 read direction in e0
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic doReq(input logic [7:0] op, input logic [31:0] a, input logic w,
                       input logic expDeny, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqOpcode = op; reqAddr = a; reqWrite = w;
    @(negedge clk);
    reqValid = 1'b0;
    chk({tag, " valid"}, 32'(respValid), 32'd1);
    chk({tag, " deny"}, 32'(respDeny), 32'(expDeny));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 respValid", 32'(respValid), 0);
    chk("R1 respDeny", 32'(respDeny), 0);
    chk("R1 violation", 32'(violation), 0);
    doReq(8'hD8, 32'h00002000, 1'b1, 1'b0, "R1 nothing guarded");

    cfgWrite(3'd4, 32'h0000FF00);
    cfgWrite(3'd0, 32'h00000202);
    cfgWrite(3'd1, 32'h00000501);
    cfgWrite(3'd2, 32'h00000710);
    cfgWrite(3'd5, 32'h0003D802);

    for (int i = 0; i < 14; i++) begin
      doReq(VEC[i][41:34], VEC[i][33:2], VEC[i][1], VEC[i][0], "R7 table");
    end

    chk("R9 set after denies", 32'(violation), 1);
    cfgWrite(3'd6, 32'h1);
    chk("R9 cleared", 32'(violation), 0);

    // deny and clear in the same cycle: set wins
    @(negedge clk);
    reqValid = 1'b1; reqOpcode = 8'hD8; reqAddr = 32'hFF002000; reqWrite = 1'b1;
    cfgWrEn = 1'b1; cfgAddr = 3'd6; cfgWrData = 32'h1;
    @(negedge clk);
    reqValid = 1'b0; cfgWrEn = 1'b0;
    chk("R9 collide deny", 32'(respDeny), 1);
    chk("R9 collide flag", 32'(violation), 1);
    @(negedge clk);
    chk("R8 idle valid", 32'(respValid), 0);
    chk("R8 idle deny", 32'(respDeny), 0);

    cfgWrite(3'd5, 32'h000000AB);
    doReq(8'hAB, 32'hFF002000, 1'b1, 1'b0, "R6 second write ignored");
    doReq(8'hD8, 32'hFF002000, 1'b1, 1'b1, "R6 first value kept");

    cfgWrite(3'd3, 32'hFFFFF800);
    doReq(8'hD8, 32'hFF000000, 1'b1, 1'b0, "R2 upper bits dropped");
    cfgWrite(3'd3, 32'h00000200);
    doReq(8'hD8, 32'hFF000000, 1'b1, 1'b1, "R2 index zero active");

    // request alongside an entry rewrite uses the old entry
    @(negedge clk);
    reqValid = 1'b1; reqOpcode = 8'hD8; reqAddr = 32'hFF000000; reqWrite = 1'b1;
    cfgWrEn = 1'b1; cfgAddr = 3'd3; cfgWrData = 32'h0;
    @(negedge clk);
    reqValid = 1'b0; cfgWrEn = 1'b0;
    chk("R11 old entry", 32'(respDeny), 1);
    doReq(8'hD8, 32'hFF000000, 1'b1, 1'b0, "R11 new entry");

    cfgWrite(3'd4, 32'h0000FE00);
    doReq(8'hD8, 32'hFF002000, 1'b1, 1'b0, "R4 old window");
    doReq(8'hD8, 32'hFE002000, 1'b1, 1'b1, "R4 new window");

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule